// File: doc/BRIEF.md
# Register-to-Memory Width Adapter

This block sits between a processor's register file and a banked on-chip memory with 64-bit rows. Each register load or store that it receives becomes one memory transfer of the right width. Each bank has its own width bit that chooses narrow (32-bit) or wide (48-bit) normal words. A long-word flag forces a full 64-bit transfer. A dedicated bus-exchange register path always moves 48-bit words, or 64-bit words with the long-word flag. General registers hold 40 bits. The block left-justifies them into the memory word: it truncates low bits on narrow stores and zero-fills low bits on narrow loads.

When the dual-element mode input is high, a normal access also makes an implicit second transfer. That transfer goes between the same register index in the secondary register file and the next address. It is issued in the cycle after the explicit one, and `busy` stalls new requests while it is issued. The memory is synchronous: read data arrives one cycle after the read is issued and goes straight back to the register file on the write-back port.

Top module: `madp_top`

## Requirements
- R1: A normal store to a bank whose width bit is 0 writes register bits [39:8] into row bits [31:0] with `mem_be` = 8'h0F. Only those four byte lanes of the row change.
- R2: A normal load from a bank whose width bit is 0 returns `wb_data` = {24'h0, row[31:0], 8'h00}.
- R3: A normal access to a bank whose width bit is 1 stores {register[39:0], 8'h00} into row bits [47:0] with `mem_be` = 8'h3F. A load from such a bank returns `wb_data` = {24'h0, row[47:8]}.
- R4: A bus-exchange access (`req_px`=1) without the long-word flag moves 48 bits whatever the bank's width bit. A store writes data bits [47:0] into row bits [47:0] with `mem_be` = 8'h3F. A load returns {16'h0, row[47:0]}.
- R5: With `req_long`=1 the transfer is 64 bits with `mem_be` = 8'hFF, whatever the bank's width bit. A normal register store writes {register[39:0], 24'h0} and a normal load returns {24'h0, row[63:24]}. A bus-exchange access moves all 64 bits unchanged.
- R6: The long-word flag overrides dual-element mode. Only one transfer is made and `busy` stays low.
- R7: In dual-element mode, a normal access issues the explicit transfer in the cycle of the request. In the next cycle it issues the implicit transfer with `busy`=1, to the explicit address plus 1 (wrapping), using secondary data `req_wdata_s`. The width of the implicit transfer comes from the bank of that next address. A request presented while `busy` is high is ignored.
- R8: Read data is returned on the cycle after the memory read is issued: `wb_valid`=1, with `wb_reg` equal to the register index, `wb_sec`=0 for an explicit and 1 for an implicit transfer, and `wb_px` marking a bus-exchange load.
- R9: Bus-exchange accesses never create an implicit transfer, even in dual-element mode.
- R10: The bank of an address is its top log2(BANKS) bits. After reset, `busy` and `wb_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Word address of the explicit transfer |
| req_reg | input | REG_IDX_W | Register index (primary file, or secondary for the implicit transfer) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_px | input | 1 | Access uses the bus-exchange register |
| req_long | input | 1 | Long-word flag, forces 64-bit transfer |
| req_wdata_p | input | 64 | Store data of the primary/explicit register (40-bit registers in [39:0]) |
| req_wdata_s | input | 64 | Store data of the secondary register for the implicit transfer |
| bank_wide | input | BANKS | Per-bank width bit: 0 = 32-bit, 1 = 48-bit words |
| dual_mode | input | 1 | Dual-element mode enable |
| busy | output | 1 | Implicit transfer in progress, requests ignored |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory row address |
| mem_be | output | 8 | Byte-lane enables |
| mem_wdata | output | 64 | Memory write row |
| mem_rdata | input | 64 | Memory read row, one cycle after the read |
| wb_valid | output | 1 | Write-back to register file |
| wb_sec | output | 1 | Write-back targets the secondary file |
| wb_px | output | 1 | Write-back targets the bus-exchange register |
| wb_reg | output | REG_IDX_W | Write-back register index |
| wb_data | output | 64 | Write-back data |

## Verification
Every cycle, the assertions check the pairing and timing rules. An implicit transfer lasts one cycle and goes to the previous address plus one. Long-word and bus-exchange requests never start one. Bus-exchange transfers enable at least 48 bits of lanes, and long-word transfers all lanes. Write-back follows a memory read by exactly one cycle. Only the bench's scenarios can show the data itself: the bit alignment for each width, the truncation and zero-fill, that unaddressed lanes keep their contents, and the width change when an implicit transfer crosses into a bank of another width.

// File: rtl/madp_pkg.sv
package madp_pkg;

    localparam int ROW_W   = 64;
    localparam int LANES   = ROW_W / 8;
    localparam int GREG_W  = 40;

    typedef enum logic [1:0] {
        WID_32 = 2'd0,
        WID_48 = 2'd1,
        WID_64 = 2'd2
    } wid_e;

    typedef struct packed {
        logic [ROW_W-1:0] data;
        logic [LANES-1:0] be;
    } lane_t;

    // Place register data into a memory row for a store.
    function automatic lane_t store_fmt(wid_e w, logic px, logic [ROW_W-1:0] src);
        lane_t o;
        o.data = '0;
        o.be   = '0;
        case (w)
            WID_32: begin
                o.data[31:0] = src[GREG_W-1:8];
                o.be         = 8'h0F;
            end
            WID_48: begin
                o.data[47:0] = px ? src[47:0] : {src[GREG_W-1:0], 8'h00};
                o.be         = 8'h3F;
            end
            default: begin
                o.data = px ? src : {src[GREG_W-1:0], 24'h0};
                o.be   = 8'hFF;
            end
        endcase
        return o;
    endfunction

    // Extract register data from a memory row for a load.
    function automatic logic [ROW_W-1:0] load_fmt(wid_e w, logic px, logic [ROW_W-1:0] row);
        logic [ROW_W-1:0] o;
        case (w)
            WID_32:  o = {24'h0, row[31:0], 8'h00};
            WID_48:  o = px ? {16'h0, row[47:0]} : {24'h0, row[47:8]};
            default: o = px ? row : {24'h0, row[63:24]};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/madp_width_sel.sv
module madp_width_sel
    import madp_pkg::*;
(
    input  logic px,
    input  logic long_word,
    input  logic bank_is_wide,
    output wid_e wid
);
    always_comb begin
        if (long_word)
            wid = WID_64;
        else if (px || bank_is_wide)
            wid = WID_48;
        else
            wid = WID_32;
    end
endmodule

// File: rtl/madp_lane_fmt.sv
module madp_lane_fmt
    import madp_pkg::*;
(
    input  wid_e             st_wid,
    input  logic             st_px,
    input  logic [ROW_W-1:0] st_src,
    output lane_t            st_lane,
    input  wid_e             ld_wid,
    input  logic             ld_px,
    input  logic [ROW_W-1:0] ld_row,
    output logic [ROW_W-1:0] ld_data
);
    always_comb begin
        st_lane = store_fmt(st_wid, st_px, st_src);
        ld_data = load_fmt(ld_wid, ld_px, ld_row);
    end
endmodule

// File: rtl/madp_seq.sv
module madp_seq
    import madp_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int REG_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc,
    input  logic                 spawn,
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic [REG_IDX_W-1:0] reg_in,
    input  logic                 we_in,
    input  logic [ROW_W-1:0]     sdata_in,
    input  logic                 issue_rd,
    input  wid_e                 cur_wid,
    input  logic                 cur_px,
    input  logic                 cur_sec,
    input  logic [REG_IDX_W-1:0] cur_reg,
    output logic                 busy,
    output logic [ADDR_W-1:0]    p_addr,
    output logic [REG_IDX_W-1:0] p_reg,
    output logic                 p_we,
    output logic [ROW_W-1:0]     p_sdata,
    output logic                 rd_valid,
    output wid_e                 rd_wid,
    output logic                 rd_px,
    output logic                 rd_sec,
    output logic [REG_IDX_W-1:0] rd_reg
);
    // Pending implicit transfer
    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            p_addr  <= '0;
            p_reg   <= '0;
            p_we    <= 1'b0;
            p_sdata <= '0;
        end else begin
            busy <= acc && spawn;
            if (acc && spawn) begin
                p_addr  <= addr_in + 1'b1;
                p_reg   <= reg_in;
                p_we    <= we_in;
                p_sdata <= sdata_in;
            end
        end
    end

    // Read context for the cycle the row returns
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_wid   <= WID_32;
            rd_px    <= 1'b0;
            rd_sec   <= 1'b0;
            rd_reg   <= '0;
        end else begin
            rd_valid <= issue_rd;
            if (issue_rd) begin
                rd_wid <= cur_wid;
                rd_px  <= cur_px;
                rd_sec <= cur_sec;
                rd_reg <= cur_reg;
            end
        end
    end

    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy); // R7
endmodule

// File: rtl/madp_top.sv
module madp_top
    import madp_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int BANKS     = 4,
    parameter int REG_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [REG_IDX_W-1:0] req_reg,
    input  logic                 req_write,
    input  logic                 req_px,
    input  logic                 req_long,
    input  logic [63:0]          req_wdata_p,
    input  logic [63:0]          req_wdata_s,
    input  logic [BANKS-1:0]     bank_wide,
    input  logic                 dual_mode,
    output logic                 busy,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [7:0]           mem_be,
    output logic [63:0]          mem_wdata,
    input  logic [63:0]          mem_rdata,
    output logic                 wb_valid,
    output logic                 wb_sec,
    output logic                 wb_px,
    output logic [REG_IDX_W-1:0] wb_reg,
    output logic [63:0]          wb_data
);
    localparam int BANK_W = $clog2(BANKS);

    logic                 acc, spawn;
    logic [ADDR_W-1:0]    sel_addr, p_addr;
    logic [REG_IDX_W-1:0] sel_reg, p_reg, rd_reg;
    logic                 sel_we, sel_px, sel_long, p_we;
    logic [ROW_W-1:0]     sel_src, p_sdata;
    logic [BANK_W-1:0]    sel_bank;
    logic                 sel_wide;
    wid_e                 sel_wid, rd_wid;
    lane_t                lane;
    logic                 rd_valid, rd_px, rd_sec;

    assign acc   = req_valid && !busy;
    assign spawn = dual_mode && !req_long && !req_px;

    // Issue mux: the implicit transfer owns the port while busy
    always_comb begin
        if (busy) begin
            sel_addr = p_addr;
            sel_reg  = p_reg;
            sel_we   = p_we;
            sel_px   = 1'b0;
            sel_long = 1'b0;
            sel_src  = p_sdata;
        end else begin
            sel_addr = req_addr;
            sel_reg  = req_reg;
            sel_we   = req_write;
            sel_px   = req_px;
            sel_long = req_long;
            sel_src  = req_wdata_p;
        end
    end

    assign sel_bank = sel_addr[ADDR_W-1 -: BANK_W];
    assign sel_wide = bank_wide[sel_bank];

    madp_width_sel i_wsel (
        .px           (sel_px),
        .long_word    (sel_long),
        .bank_is_wide (sel_wide),
        .wid          (sel_wid)
    );

    madp_lane_fmt i_fmt (
        .st_wid  (sel_wid),
        .st_px   (sel_px),
        .st_src  (sel_src),
        .st_lane (lane),
        .ld_wid  (rd_wid),
        .ld_px   (rd_px),
        .ld_row  (mem_rdata),
        .ld_data (wb_data)
    );

    madp_seq #(.ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .spawn    (spawn),
        .addr_in  (req_addr),
        .reg_in   (req_reg),
        .we_in    (req_write),
        .sdata_in (req_wdata_s),
        .issue_rd (mem_en && !mem_we),
        .cur_wid  (sel_wid),
        .cur_px   (sel_px),
        .cur_sec  (busy),
        .cur_reg  (sel_reg),
        .busy     (busy),
        .p_addr   (p_addr),
        .p_reg    (p_reg),
        .p_we     (p_we),
        .p_sdata  (p_sdata),
        .rd_valid (rd_valid),
        .rd_wid   (rd_wid),
        .rd_px    (rd_px),
        .rd_sec   (rd_sec),
        .rd_reg   (rd_reg)
    );

    assign mem_en    = busy || acc;
    assign mem_we    = mem_en && sel_we;
    assign mem_addr  = sel_addr;
    assign mem_be    = mem_en ? lane.be : 8'h00;
    assign mem_wdata = lane.data;

    assign wb_valid = rd_valid;
    assign wb_sec   = rd_sec;
    assign wb_px    = rd_px;
    assign wb_reg   = rd_reg;

    AST_IMPLICIT_NEXT_ADDR: assert property (@(posedge clk) disable iff (rst)
        busy |-> (mem_en && mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R7
    AST_LONG_NO_PAIR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_long) |=> !busy); // R6
    AST_PX_NO_PAIR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_px) |=> !busy); // R9
    AST_PX_AT_LEAST_48: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !busy && req_px) |-> (mem_be[5:0] == 6'h3F)); // R4
    AST_LONG_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !busy && req_long) |-> (mem_be == 8'hFF)); // R5
    AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(mem_en && !mem_we)); // R8
endmodule

// File: tb/test_madp_top.sv
`timescale 1ns/1ps
module test_madp_top;
    localparam int AW = 10;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_write, req_px, req_long, dual_mode;
    logic [AW-1:0] req_addr;
    logic [RW-1:0] req_reg;
    logic [63:0]   req_wdata_p, req_wdata_s;
    logic [3:0]    bank_wide;
    logic          busy, mem_en, mem_we, wb_valid, wb_sec, wb_px;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_be;
    logic [63:0]   mem_wdata, mem_rdata, wb_data;
    logic [RW-1:0] wb_reg;

    logic [63:0]   ram [1024];
    int            n_chk = 0;
    int            n_bad = 0;

    always #2.5 clk = ~clk;

    madp_top #(.ADDR_W(AW), .BANKS(4), .REG_IDX_W(RW)) i_madp_top (
        .clk, .rst, .req_valid, .req_addr, .req_reg, .req_write, .req_px,
        .req_long, .req_wdata_p, .req_wdata_s, .bank_wide, .dual_mode,
        .busy, .mem_en, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_rdata,
        .wb_valid, .wb_sec, .wb_px, .wb_reg, .wb_data
    );

    // Synchronous memory model with byte-lane enables
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < 8; b++)
                    if (mem_be[b]) ram[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= ram[mem_addr];
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 1'b0; req_write = 1'b0; req_px = 1'b0; req_long = 1'b0;
        req_addr = '0; req_reg = '0; req_wdata_p = '0; req_wdata_s = '0;
    endtask

    task automatic drive(input logic [AW-1:0] a, input logic [RW-1:0] r, input logic we,
                         input logic px, input logic lw, input logic [63:0] dp,
                         input logic [63:0] ds);
        req_valid = 1'b1; req_addr = a; req_reg = r; req_write = we;
        req_px = px; req_long = lw; req_wdata_p = dp; req_wdata_s = ds;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 busy after reset", 64'(busy), 64'd0);
        chk("R10 wb_valid after reset", 64'(wb_valid), 64'd0);
    endtask

    task automatic t_store_narrow();
        ram[10'h010] = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk); drive(10'h010, 4'd2, 1'b1, 1'b0, 1'b0, 64'h00A1B2C3D4E5, '0);
        #1;
        chk("R1 be", 64'(mem_be), 64'h0F);
        chk("R1 wdata", 64'(mem_wdata[31:0]), 64'hA1B2C3D4);
        @(negedge clk); idle();
        chk("R1 lanes kept", ram[10'h010], 64'hFFFF_FFFF_A1B2_C3D4);
    endtask

    task automatic t_load_narrow();
        ram[10'h020] = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk); drive(10'h020, 4'd5, 1'b0, 1'b0, 1'b0, '0, '0);
        @(negedge clk); idle();
        chk("R2 data", wb_data, 64'h0000_009A_BCDE_F000);
        chk("R8 valid", 64'(wb_valid), 64'd1);
        chk("R8 tag", {wb_sec, wb_px, wb_reg}, {2'b00, 4'd5});
    endtask

    task automatic t_wide_bank();
        ram[10'h110] = '1;
        ram[10'h120] = 64'hAAAA_0102_0304_0506;
        @(negedge clk); drive(10'h110, 4'd1, 1'b1, 1'b0, 1'b0, 64'h0011_2233_4455, '0);
        #1;
        chk("R3 be", 64'(mem_be), 64'h3F);
        @(negedge clk); drive(10'h120, 4'd1, 1'b0, 1'b0, 1'b0, '0, '0);
        chk("R3 store row", ram[10'h110], 64'hFFFF_1122_3344_5500);
        @(negedge clk); idle();
        chk("R3 load", wb_data, 64'h0000_0001_0203_0405);
    endtask

    task automatic t_exchange();
        ram[10'h018] = '0;
        ram[10'h030] = 64'h7777_6666_5555_4444;
        @(negedge clk); drive(10'h018, 4'd0, 1'b1, 1'b1, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, '0);
        #1;
        chk("R4 be in narrow bank", 64'(mem_be), 64'h3F);
        @(negedge clk); drive(10'h030, 4'd0, 1'b0, 1'b1, 1'b0, '0, '0);
        chk("R4 store row", ram[10'h018], 64'h0000_BEEF_CAFE_F00D);
        @(negedge clk); idle();
        chk("R4 load", wb_data, 64'h0000_6666_5555_4444);
        chk("R8 px tag", 64'(wb_px), 64'd1);
    endtask

    task automatic t_long();
        ram[10'h040] = '0;
        ram[10'h130] = 64'h0123_4567_89AB_CDEF;
        ram[10'h041] = 64'h5A5A;
        @(negedge clk); drive(10'h040, 4'd4, 1'b1, 1'b0, 1'b1, 64'h0099_8877_6655, '0);
        #1;
        chk("R5 be", 64'(mem_be), 64'hFF);
        @(negedge clk); drive(10'h130, 4'd4, 1'b0, 1'b1, 1'b1, '0, '0);
        chk("R5 store row", ram[10'h040], 64'h9988_7766_5500_0000);
        @(negedge clk); idle();
        chk("R5 px load", wb_data, 64'h0123_4567_89AB_CDEF);
    endtask

    task automatic t_dual_store();
        ram[10'h0FF] = '1;
        ram[10'h100] = '1;
        ram[10'h300] = 64'h1111;
        dual_mode = 1'b1;
        @(negedge clk); drive(10'h0FF, 4'd3, 1'b1, 1'b0, 1'b0, 64'hF1F2F3F4F5, 64'hE1E2E3E4E5);
        #1;
        chk("R7 explicit addr", 64'(mem_addr), 64'h0FF);
        chk("R7 explicit be", 64'(mem_be), 64'h0F);
        @(negedge clk); drive(10'h300, 4'd9, 1'b1, 1'b0, 1'b0, 64'h2222, '0);
        #1;
        chk("R7 busy", 64'(busy), 64'd1);
        chk("R7 implicit addr", 64'(mem_addr), 64'h100);
        chk("R7 implicit be from next bank", 64'(mem_be), 64'h3F);
        @(negedge clk); idle();
        #1;
        chk("R7 busy cleared", 64'(busy), 64'd0);
        chk("R7 explicit row", ram[10'h0FF], 64'hFFFF_FFFF_F1F2_F3F4);
        chk("R7 implicit row", ram[10'h100], 64'hFFFF_E1E2_E3E4_E500);
        chk("R7 request while busy ignored", ram[10'h300], 64'h1111);
    endtask

    task automatic t_dual_long_px();
        ram[10'h051] = 64'h33;
        ram[10'h061] = 64'h44;
        @(negedge clk); drive(10'h050, 4'd6, 1'b1, 1'b0, 1'b1, 64'h12345, 64'h6789A);
        @(negedge clk); idle();
        #1;
        chk("R6 no pairing", {63'd0, busy}, 64'd0);
        chk("R6 next word kept", ram[10'h051], 64'h33);
        @(negedge clk); drive(10'h060, 4'd6, 1'b1, 1'b1, 1'b0, 64'h12345, 64'h6789A);
        @(negedge clk); idle();
        #1;
        chk("R9 no pairing", {63'd0, busy}, 64'd0);
        chk("R9 next word kept", ram[10'h061], 64'h44);
    endtask

    task automatic t_dual_load();
        ram[10'h200] = 64'h0000_0000_CAFE_BABE;
        ram[10'h201] = 64'h0000_0000_1357_9BDF;
        @(negedge clk); drive(10'h200, 4'd7, 1'b0, 1'b0, 1'b0, '0, '0);
        @(negedge clk); idle();
        chk("R8 explicit wb", {wb_valid, wb_sec, wb_reg}, {2'b10, 4'd7});
        chk("R7 explicit data", wb_data, 64'h0000_00CA_FEBA_BE00);
        @(negedge clk);
        chk("R8 implicit wb", {wb_valid, wb_sec, wb_reg}, {2'b11, 4'd7});
        chk("R7 implicit data", wb_data, 64'h0000_0013_579B_DF00);
        dual_mode = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle();
        dual_mode = 1'b0;
        bank_wide = 4'b1010;   // banks 1 and 3 wide
        mem_rdata = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_store_narrow();
        t_load_narrow();
        t_wide_bank();
        t_exchange();
        t_long();
        t_dual_store();
        t_dual_long_px();
        t_dual_load();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule